// File: doc/BRIEF.md
# Signed Shift-Right-Accumulate Vector Unit

This unit is one SIMD datapath stage. Each signed source element is shifted right arithmetically, and the bits shifted out are dropped. The shifted value is added to the matching accumulator element, and the sum wraps at the lane width. One 7-bit immediate, given as a 4-bit upper field and a 3-bit lower field, sets both the lane width and the shift distance.

A width bit selects either a 64-bit or a 128-bit operation. A mode bit selects scalar operation, which is always one 64-bit lane. Encodings that do not belong to this operation raise one of two flags. One flag marks an encoding that decodes to a different operation. The other marks an undefined encoding.

The logic is combinational and feeds a single register stage. That stage is loaded whenever the input valid is high. Latency is one cycle for every input value.

Top module: `ssra_vec_unit`

## Requirements
- R1: In vector mode, lane width is 8, 16, 32 or 64 bits, chosen by the highest set bit (bit 0, 1, 2 or 3) of the 4-bit upper immediate field.
- R2: The shift distance is twice the lane width minus the unsigned value of {upper field, lower field}. This gives 1 up to the lane width.
- R3: Each source lane is read as two's complement and shifted right arithmetically. Bits shifted out are discarded, with no rounding.
- R4: A shift equal to the lane width gives a shifted value of all sign bits: 0 for a non-negative lane, -1 for a negative lane.
- R5: Each result lane is accumulator lane plus shifted lane, taken modulo 2^width, with no saturation.
- R6: With the width bit at 0, only bits 63:0 are computed and bits 127:64 of the result are 0. With the width bit at 1, all 128 bits are computed.
- R7: In vector mode, an upper field of 0000 sets the other-encoding flag to 1, leaves the undefined flag at 0, and makes the result 0.
- R8: In vector mode, 64-bit lanes with the width bit at 0 set the undefined flag to 1 and make the result 0.
- R9: Scalar mode uses one 64-bit lane in bits 63:0, with shift 128 minus the immediate, and bits 127:64 at 0. The width bit is ignored. An upper-field bit 3 of 0 sets the undefined flag and makes the result 0.
- R10: Outputs are loaded on the rising edge when the input valid is high. The output valid equals the input valid one cycle earlier. When the input valid is low, the result and flags hold their values.
- R11: A synchronous active-high reset clears the output valid, the result and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| src | input | 128 | Source vector |
| acc | input | 128 | Accumulator vector |
| imm_hi | input | 4 | Upper immediate field |
| imm_lo | input | 3 | Lower immediate field |
| wide | input | 1 | 1 selects a 128-bit operation, 0 a 64-bit operation |
| scalar_mode | input | 1 | 1 selects a single 64-bit lane |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Accumulated result |
| undef_flag | output | 1 | Undefined encoding |
| alt_enc | output | 1 | Encoding belongs to another operation |

## Verification
The properties assume that reset is held for at least one edge before the first valid input. They also assume that flags and result are judged only in cycles where the output valid is high. The mode, width and immediate inputs are taken to be stable across the edge that loads them. The stimulus meets these assumptions by applying reset first. It changes inputs only on the falling edge and raises the input valid for exactly one cycle per operation. It reads outputs one falling edge later.

// File: rtl/ssra_vec_unit.sv
module ssra_vec_unit #(
  parameter int VW   = 128,
  parameter int HALF = VW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [VW-1:0] src,
  input  logic [VW-1:0] acc,
  input  logic [3:0]    imm_hi,
  input  logic [2:0]    imm_lo,
  input  logic          wide,
  input  logic          scalar_mode,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic          undef_flag,
  output logic          alt_enc
);

  logic [6:0]    imm;
  logic [1:0]    sz;
  logic [7:0]    sh;
  logic          bad, other;
  logic [VW-1:0] lane_res [4];
  logic [VW-1:0] picked, masked;

  assign imm = {imm_hi, imm_lo};

  assign sz = scalar_mode ? 2'd3 :
              imm_hi[3]   ? 2'd3 :
              imm_hi[2]   ? 2'd2 :
              imm_hi[1]   ? 2'd1 : 2'd0;

  assign sh = (8'd16 << sz) - {1'b0, imm};

  assign other = !scalar_mode && (imm_hi == 4'b0000);
  assign bad   = scalar_mode ? !imm_hi[3] : (imm_hi[3] && !wide);

  for (genvar g = 0; g < 4; g++) begin : g_size
    localparam int         EW = 8 << g;
    localparam int         NL = VW / EW;
    localparam logic [7:0] EL = 8'(EW);
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic signed [EW-1:0] s, shr, fill;
      assign s    = src[l*EW +: EW];
      assign shr  = s >>> sh;
      assign fill = (sh >= EL) ? {EW{s[EW-1]}} : shr;
      assign lane_res[g][l*EW +: EW] = acc[l*EW +: EW] + fill;
    end
  end

  assign picked = lane_res[sz];
  assign masked = (wide && !scalar_mode) ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      undef_flag <= 1'b0;
      alt_enc    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= (bad || other) ? '0 : masked;
        undef_flag <= bad;
        alt_enc    <= other;
      end
    end
  end

endmodule

module ssra_vec_unit_chk #(
  parameter int VW   = 128,
  parameter int HALF = VW / 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [VW-1:0] src,
  input logic [VW-1:0] acc,
  input logic [3:0]    imm_hi,
  input logic [2:0]    imm_lo,
  input logic          wide,
  input logic          scalar_mode,
  input logic          out_valid,
  input logic [VW-1:0] result,
  input logic          undef_flag,
  input logic          alt_enc
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> $stable(result) && $stable(undef_flag));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!wide || scalar_mode)) |=> (result[VW-1:HALF] == '0));

  // R7
  alt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scalar_mode && imm_hi == 4'b0000) |=> (alt_enc && !undef_flag && result == '0));

  // R8
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scalar_mode && imm_hi[3] && !wide) |=> (undef_flag && result == '0));

  // R9
  scalar_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_mode && !imm_hi[3]) |=> (undef_flag && !alt_enc && result == '0));

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(undef_flag && alt_enc));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !undef_flag && !alt_enc));

endmodule

bind ssra_vec_unit ssra_vec_unit_chk #(.VW(VW), .HALF(HALF)) u_chk (.*);

// File: tb/tb_ssra_vec_unit.sv
`timescale 1ns/1ps
module tb_ssra_vec_unit;

  typedef struct packed {
    logic [127:0] src;
    logic [127:0] acc;
    logic [127:0] exp;
    logic [3:0]   hi;
    logic [2:0]   lo;
    logic         q;
    logic         sc;
    logic         un;
    logic         alt;
    int           req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R1 R2 R3: 8-bit lanes, shift 1
    '{{16{8'h80}}, {16{8'h01}}, {16{8'hC1}}, 4'b0001, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 3},
    // R4: 8-bit lanes, shift 8
    '{{8{16'h7F80}}, {16{8'h05}}, {8{16'h0504}}, 4'b0001, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 4},
    // R5: 16-bit wrap, shift 1
    '{{8{16'h7FFE}}, {8{16'h7FFF}}, {8{16'hBFFE}}, 4'b0011, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 5},
    // R2: 32-bit lanes, shift 16
    '{{4{32'h80012345}}, {4{32'h00000001}}, {4{32'hFFFF8002}}, 4'b0110, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 2},
    // R4: 64-bit lanes, shift 64
    '{{64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF}, {64'd10, 64'd20}, {64'd9, 64'd20},
      4'b1000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 4},
    // R5: 64-bit lanes, shift 1, wrap
    '{{64'hFFFFFFFFFFFFFFFE, 64'h10}, {64'h1, 64'hFFFFFFFFFFFFFFFF}, {64'h0, 64'h7},
      4'b1111, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 5},
    // R6: 64-bit operation, 8-bit lanes
    '{{16{8'h80}}, {16{8'h01}}, {64'h0, {8{8'hC1}}}, 4'b0001, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 6},
    // R7: upper field 0000
    '{{16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0000, 3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 7},
    // R8: 64-bit lanes with width bit 0
    '{{16{8'h11}}, {16{8'h22}}, 128'h0, 4'b1000, 3'b011, 1'b0, 1'b0, 1'b1, 1'b0, 8},
    // R9: scalar, shift 63, width bit ignored
    '{{64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000}, {64'h7, 64'h5}, {64'h0, 64'h4},
      4'b1000, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 9},
    // R9: scalar with bit 3 clear
    '{{16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0111, 3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 9},
    // R9: scalar with upper field 0000 is undefined, not other
    '{{16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 9},
    // R4: 16-bit lanes, shift 16
    '{{8{16'h8000}}, {8{16'h0003}}, {8{16'h0002}}, 4'b0010, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 4},
    // R6: 32-bit lanes, shift 32, width bit 0
    '{{4{32'h7FFFFFFF}}, {4{32'h12345678}}, {64'h0, {2{32'h12345678}}},
      4'b0100, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 6}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0, acc = '0;
  logic [3:0]   imm_hi = '0;
  logic [2:0]   imm_lo = '0;
  logic         wide = 1'b0, scalar_mode = 1'b0;
  logic         out_valid, undef_flag, alt_enc;
  logic [127:0] result;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ssra_vec_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .acc(acc),
    .imm_hi(imm_hi), .imm_lo(imm_lo), .wide(wide), .scalar_mode(scalar_mode),
    .out_valid(out_valid), .result(result), .undef_flag(undef_flag), .alt_enc(alt_enc)
  );

  task automatic check(input string rq, input logic [130:0] act, input logic [130:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    src = v.src; acc = v.acc; imm_hi = v.hi; imm_lo = v.lo;
    wide = v.q; scalar_mode = v.sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {out_valid, undef_flag, alt_enc, result}, 131'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d vec %0d", TBL[i].req, i),
            {out_valid, TBL[i].un ? undef_flag : undef_flag, alt_enc, result},
            {1'b1, TBL[i].un, TBL[i].alt, TBL[i].exp});
    end

    // R10: hold while input valid is low
    apply(TBL[0]);
    src = '1; acc = '1; imm_hi = 4'b1000; wide = 1'b1;
    @(negedge clk);
    check("R10 hold", {out_valid, undef_flag, alt_enc, result}, {3'b000, {16{8'hC1}}});

    // R10: back-to-back valid inputs update every cycle
    @(negedge clk);
    src = TBL[2].src; acc = TBL[2].acc; imm_hi = TBL[2].hi; imm_lo = TBL[2].lo;
    wide = 1'b1; scalar_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R10 b2b first", {out_valid, result}, {1'b1, TBL[2].exp});
    src = TBL[12].src; acc = TBL[12].acc; imm_hi = TBL[12].hi; imm_lo = TBL[12].lo;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 b2b second", {out_valid, result}, {1'b1, TBL[12].exp});

    // R11: reset mid-run clears loaded outputs
    apply(TBL[8]);
    rst = 1'b1;
    @(negedge clk);
    check("R11 mid-run", {out_valid, undef_flag, alt_enc, result}, 131'h0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule